// File: doc/BRIEF.md
# Breakpoint Condition Comparator

This block judges one set of breakpoint conditions against every processor bus cycle. For each cycle it compares three things. The bus address is checked against a pair of limit registers, either for one address, for an inclusive window or for everything outside that window. The data bus is checked against a reference value with a per-bit ignore mask, on a byte, word or longword lane picked by the control word. The program counter is checked against a reference under its own ignore mask, with an optional inverted sense.

A 16-bit control word chooses which comparator classes take part and how each one behaves. The block reports a hit flag for each class. It also reports a combined "condition met" flag, which is the AND of every class that is enabled. All results are registered and appear one clock after the bus cycle strobe, together with a result-valid flag. A trigger sequencer further up the chip consumes these flags. Loading the limit, reference and mask registers happens outside this block. The block receives their values as plain inputs.

Top module: `bkpt_cmp`

## Requirements
- R1: Results are registered. One clock after a cycle with `busStrobe` high, `resultValid` is 1 and the four flags show that cycle's outcome. After a clock with `busStrobe` low, `resultValid` and all four flags are 0, and all outputs are 0 out of reset.
- R2: Control bit 13 is the global enable. When it is 0, every hit flag and `condMet` is 0, whatever the other control bits say.
- R3: Control bit 2 selects single-address mode. The address class matches when `busAddr` equals `addrLow`.
- R4: Control bit 3 selects window mode. The address class matches when `addrLow <= busAddr <= addrHigh`, with both limits included.
- R5: Control bit 4 selects outside mode. The address class matches when `busAddr` is below `addrLow` or above `addrHigh`. If more than one of bits 4..2 is set, any selected mode matching is enough. If all three are 0, the address class is disabled and `addrHit` stays 0.
- R6: Control bits 12..6 enable the data lanes. The lanes and the accesses that cover them are:
  - bit 12: data[31:0], covered by any longword access (`busSize`=2).
  - bit 11: data[15:0], covered by a word access (`busSize`=1) with `busAddr[1]`=1.
  - bit 10: data[31:16], covered by a word access with `busAddr[1]`=0.
  - bits 9, 8, 7 and 6: data[7:0], [15:8], [23:16] and [31:24], covered by a byte access (`busSize`=0) at byte offsets `busAddr[1:0]` = 3, 2, 1 and 0.
  - A lane can match only on a cycle that covers it. `busSize`=3 covers no lane.
  - The data class matches if any enabled lane matches. With bits 12..6 all 0, the data class is disabled.
- R7: Data bits where `dataIgnore` is 1 are left out of the lane comparison.
- R8: Control bit 5 inverts every data lane comparison. A covered, enabled lane then matches when its unmasked bits differ from `dataRef`.
- R9: Control bit 1 enables the PC class. It matches when `((busPc ^ pcRef) & ~pcIgnore) == 0`.
- R10: Control bit 0 inverts the PC comparison, so the PC class matches when the PC lies outside the masked region.
- R11: `condMet` is 1 only when the global enable is set, at least one class is enabled, and every enabled class matches. Each hit flag is 0 for a disabled class.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| busStrobe | input | 1 | Bus cycle present this clock |
| busAddr | input | ADDR_W | Bus cycle address |
| busData | input | 32 | Bus cycle data |
| busSize | input | 2 | Transfer size: 0 byte, 1 word, 2 longword |
| busPc | input | PC_W | Program counter of the cycle |
| ctrlWord | input | 16 | Condition control field |
| addrLow | input | ADDR_W | Low address limit |
| addrHigh | input | ADDR_W | High address limit |
| dataRef | input | 32 | Data reference value |
| dataIgnore | input | 32 | Data bits excluded from comparison (1 = ignore) |
| pcRef | input | PC_W | PC reference value |
| pcIgnore | input | PC_W | PC bits excluded from comparison (1 = ignore) |
| addrHit | output | 1 | Address class matched |
| dataHit | output | 1 | Data class matched |
| pcHit | output | 1 | PC class matched |
| condMet | output | 1 | All enabled classes matched |
| resultValid | output | 1 | Flags refer to the previous strobed cycle |

## Verification
The address window and the inverted data lanes are judged in the same strobed cycle. One case puts an address exactly on the high limit together with data that differs from the reference on a longword access. A companion case moves the address one past the limit and keeps the data the same. The scoreboard expects `condMet` to be 1 in the first case and 0 in the second, while `dataHit` stays 1 in both. This shows that the AND combines two classes that are each correct on their own, and not a single comparator. A PC mismatch paired with an exact address hit checks the same rule from the PC side.

// File: rtl/bkpt_cmp_pkg.sv
package bkpt_cmp_pkg;

  localparam int DATA_W    = 32;
  localparam int NUM_LANES = 7;
  localparam int CTRL_W    = 16;

  localparam logic [1:0] SZ_BYTE = 2'd0;
  localparam logic [1:0] SZ_WORD = 2'd1;
  localparam logic [1:0] SZ_LONG = 2'd2;

  // Control-field bit positions (the sequencer above decodes the same layout).
  localparam int BIT_EN     = 13;
  localparam int BIT_LANE_HI = 12;
  localparam int BIT_LANE_LO = 6;
  localparam int BIT_DINV   = 5;
  localparam int BIT_AOUT   = 4;
  localparam int BIT_ARNG   = 3;
  localparam int BIT_AEQ    = 2;
  localparam int BIT_PCEN   = 1;
  localparam int BIT_PCINV  = 0;

  // Strobes from control to datapath.
  typedef struct packed {
    logic                 sample;
    logic                 globalEn;
    logic                 addrEq;
    logic                 addrIn;
    logic                 addrOut;
    logic [NUM_LANES-1:0] laneEn;   // index 6 longword ... index 0 byte [31:24]
    logic                 dataInv;
    logic                 pcEn;
    logic                 pcInv;
  } ctrl_strobe_t;

  // Data bits belonging to a lane.
  function automatic logic [DATA_W-1:0] laneBits(input int idx);
    case (idx)
      6:       laneBits = 32'hFFFF_FFFF;
      5:       laneBits = 32'h0000_FFFF;
      4:       laneBits = 32'hFFFF_0000;
      3:       laneBits = 32'h0000_00FF;
      2:       laneBits = 32'h0000_FF00;
      1:       laneBits = 32'h00FF_0000;
      default: laneBits = 32'hFF00_0000;
    endcase
  endfunction

  // Whether a transfer of the given size and offset covers a lane.
  function automatic logic laneCovered(input int idx, input logic [1:0] sz,
                                       input logic [1:0] off);
    case (idx)
      6:       laneCovered = (sz == SZ_LONG);
      5:       laneCovered = (sz == SZ_WORD) && off[1];
      4:       laneCovered = (sz == SZ_WORD) && !off[1];
      3:       laneCovered = (sz == SZ_BYTE) && (off == 2'd3);
      2:       laneCovered = (sz == SZ_BYTE) && (off == 2'd2);
      1:       laneCovered = (sz == SZ_BYTE) && (off == 2'd1);
      default: laneCovered = (sz == SZ_BYTE) && (off == 2'd0);
    endcase
  endfunction

endpackage

// File: rtl/bkpt_cmp_ctrl.sv
module bkpt_cmp_ctrl
  import bkpt_cmp_pkg::*;
(
  input  logic              busStrobe,
  input  logic [CTRL_W-1:0] ctrlWord,
  output ctrl_strobe_t      ctl
);

  logic unusedBits;
  assign unusedBits = ^ctrlWord[CTRL_W-1:BIT_EN+1];

  always_comb begin
    ctl          = '0;
    ctl.sample   = busStrobe;
    ctl.globalEn = ctrlWord[BIT_EN];
    ctl.addrEq   = ctrlWord[BIT_AEQ];
    ctl.addrIn   = ctrlWord[BIT_ARNG];
    ctl.addrOut  = ctrlWord[BIT_AOUT];
    ctl.laneEn   = ctrlWord[BIT_LANE_HI:BIT_LANE_LO];
    ctl.dataInv  = ctrlWord[BIT_DINV];
    ctl.pcEn     = ctrlWord[BIT_PCEN];
    ctl.pcInv    = ctrlWord[BIT_PCINV];
  end

endmodule

// File: rtl/bkpt_cmp_dp.sv
module bkpt_cmp_dp
  import bkpt_cmp_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int PC_W   = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrl_strobe_t      ctl,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] busData,
  input  logic [1:0]        busSize,
  input  logic [PC_W-1:0]   busPc,
  input  logic [ADDR_W-1:0] addrLow,
  input  logic [ADDR_W-1:0] addrHigh,
  input  logic [DATA_W-1:0] dataRef,
  input  logic [DATA_W-1:0] dataIgnore,
  input  logic [PC_W-1:0]   pcRef,
  input  logic [PC_W-1:0]   pcIgnore,
  output logic              addrHit,
  output logic              dataHit,
  output logic              pcHit,
  output logic              condMet,
  output logic              resultValid
);

  // Address comparators
  logic aboveLow, belowHigh, inWindow, eqLow, addrOn, addrMatch;
  assign aboveLow  = (busAddr >= addrLow);
  assign belowHigh = (busAddr <= addrHigh);
  assign inWindow  = aboveLow && belowHigh;
  assign eqLow     = (busAddr == addrLow);
  assign addrOn    = ctl.addrEq | ctl.addrIn | ctl.addrOut;
  assign addrMatch = (ctl.addrEq && eqLow) || (ctl.addrIn && inWindow)
                  || (ctl.addrOut && !inWindow);

  // Data lane comparators
  logic [DATA_W-1:0]    dataDiff;
  logic [NUM_LANES-1:0] laneMatch;
  logic                 dataOn, dataMatch;
  assign dataDiff = (busData ^ dataRef) & ~dataIgnore;

  for (genvar i = 0; i < NUM_LANES; i++) begin : g_lane
    logic covered, eqLane;
    assign covered      = laneCovered(i, busSize, busAddr[1:0]);
    assign eqLane       = ((dataDiff & laneBits(i)) == '0);
    assign laneMatch[i] = covered && (eqLane ^ ctl.dataInv);
  end

  assign dataOn    = |ctl.laneEn;
  assign dataMatch = |(laneMatch & ctl.laneEn);

  // PC comparator
  logic pcEq, pcMatch;
  assign pcEq    = (((busPc ^ pcRef) & ~pcIgnore) == '0);
  assign pcMatch = pcEq ^ ctl.pcInv;

  // Combination of enabled classes
  logic anyOn, allOk, live;
  assign live  = ctl.sample && ctl.globalEn;
  assign anyOn = addrOn || dataOn || ctl.pcEn;
  assign allOk = (!addrOn || addrMatch) && (!dataOn || dataMatch)
              && (!ctl.pcEn || pcMatch);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addrHit     <= 1'b0;
      dataHit     <= 1'b0;
      pcHit       <= 1'b0;
      condMet     <= 1'b0;
      resultValid <= 1'b0;
    end else begin
      resultValid <= ctl.sample;
      addrHit     <= live && addrOn && addrMatch;
      dataHit     <= live && dataOn && dataMatch;
      pcHit       <= live && ctl.pcEn && pcMatch;
      condMet     <= live && anyOn && allOk;
    end
  end

endmodule

// File: rtl/bkpt_cmp.sv
module bkpt_cmp
  import bkpt_cmp_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int PC_W   = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busStrobe,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [31:0]       busData,
  input  logic [1:0]        busSize,
  input  logic [PC_W-1:0]   busPc,
  input  logic [15:0]       ctrlWord,
  input  logic [ADDR_W-1:0] addrLow,
  input  logic [ADDR_W-1:0] addrHigh,
  input  logic [31:0]       dataRef,
  input  logic [31:0]       dataIgnore,
  input  logic [PC_W-1:0]   pcRef,
  input  logic [PC_W-1:0]   pcIgnore,
  output logic              addrHit,
  output logic              dataHit,
  output logic              pcHit,
  output logic              condMet,
  output logic              resultValid
);

  ctrl_strobe_t ctl;

  bkpt_cmp_ctrl u_ctrl (
    .busStrobe (busStrobe),
    .ctrlWord  (ctrlWord),
    .ctl       (ctl)
  );

  bkpt_cmp_dp #(.ADDR_W(ADDR_W), .PC_W(PC_W)) u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .ctl         (ctl),
    .busAddr     (busAddr),
    .busData     (busData),
    .busSize     (busSize),
    .busPc       (busPc),
    .addrLow     (addrLow),
    .addrHigh    (addrHigh),
    .dataRef     (dataRef),
    .dataIgnore  (dataIgnore),
    .pcRef       (pcRef),
    .pcIgnore    (pcIgnore),
    .addrHit     (addrHit),
    .dataHit     (dataHit),
    .pcHit       (pcHit),
    .condMet     (condMet),
    .resultValid (resultValid)
  );

endmodule

// File: rtl/bkpt_cmp_chk.sv
module bkpt_cmp_chk #(
  parameter int ADDR_W = 32,
  parameter int PC_W   = 32
) (
  input logic              clk,
  input logic              rstN,
  input logic              busStrobe,
  input logic [ADDR_W-1:0] busAddr,
  input logic [31:0]       busData,
  input logic [15:0]       ctrlWord,
  input logic [ADDR_W-1:0] addrLow,
  input logic              addrHit,
  input logic              dataHit,
  input logic              pcHit,
  input logic              condMet,
  input logic              resultValid
);

  AST_VALID_AFTER_STROBE: assert property (@(posedge clk) disable iff (!rstN)
    busStrobe |=> resultValid); // R1

  AST_QUIET_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    !busStrobe |=> !(resultValid || addrHit || dataHit || pcHit || condMet)); // R1

  AST_DISABLED_SILENT: assert property (@(posedge clk) disable iff (!rstN)
    (busStrobe && !ctrlWord[13]) |=> !(addrHit || dataHit || pcHit || condMet)); // R2

  AST_EXACT_ADDR_HIT: assert property (@(posedge clk) disable iff (!rstN)
    (busStrobe && ctrlWord[13] && ctrlWord[2] && (busAddr == addrLow)) |=> addrHit); // R3

  AST_NO_LANE_NO_DATA: assert property (@(posedge clk) disable iff (!rstN)
    (busStrobe && (ctrlWord[12:6] == 7'd0)) |=> !dataHit); // R6

  AST_NO_PC_WHEN_OFF: assert property (@(posedge clk) disable iff (!rstN)
    (busStrobe && !ctrlWord[1]) |=> !pcHit); // R9

  AST_MET_NEEDS_HIT: assert property (@(posedge clk) disable iff (!rstN)
    condMet |-> (addrHit || dataHit || pcHit)); // R11

  logic unusedData;
  assign unusedData = ^busData;

endmodule

bind bkpt_cmp bkpt_cmp_chk #(.ADDR_W(ADDR_W), .PC_W(PC_W)) u_chk (.*);

// File: tb/tb_bkpt_cmp.sv
module tb_bkpt_cmp;

  localparam int AW = 32;
  localparam int PW = 32;

  // Control-field bits
  localparam logic [15:0] EN    = 16'h2000; // bit 13
  localparam logic [15:0] LONG  = 16'h1000; // bit 12
  localparam logic [15:0] LWORD = 16'h0800; // bit 11
  localparam logic [15:0] UWORD = 16'h0400; // bit 10
  localparam logic [15:0] BY0   = 16'h0200; // bit 9, data[7:0]
  localparam logic [15:0] BY3   = 16'h0040; // bit 6, data[31:24]
  localparam logic [15:0] DINV  = 16'h0020; // bit 5
  localparam logic [15:0] AOUT  = 16'h0010; // bit 4
  localparam logic [15:0] ARNG  = 16'h0008; // bit 3
  localparam logic [15:0] AEQ   = 16'h0004; // bit 2
  localparam logic [15:0] PCEN  = 16'h0002; // bit 1
  localparam logic [15:0] PCINV = 16'h0001; // bit 0

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          busStrobe = 1'b0;
  logic [AW-1:0] busAddr = '0;
  logic [31:0]   busData = '0;
  logic [1:0]    busSize = '0;
  logic [PW-1:0] busPc = '0;
  logic [15:0]   ctrlWord = '0;
  logic [AW-1:0] addrLow = '0, addrHigh = '0;
  logic [31:0]   dataRef = '0, dataIgnore = '0;
  logic [PW-1:0] pcRef = '0, pcIgnore = '0;
  logic          addrHit, dataHit, pcHit, condMet, resultValid;

  always #10 clk = ~clk; // 50 MHz

  bkpt_cmp #(.ADDR_W(AW), .PC_W(PW)) dut (.*);

  typedef struct {
    logic [3:0] flags; // {addr, data, pc, met}
    string      tag;
  } item_t;

  item_t sbq[$];
  int checks = 0;
  int fails  = 0;
  bit finished = 0;

  function automatic logic [3:0] model(input logic [15:0] c, input logic [AW-1:0] a,
                                       input logic [31:0] d, input logic [1:0] sz,
                                       input logic [PW-1:0] p);
    logic aOn, dOn, pOn, aM, dM, pM, inv, win;
    logic [31:0] diff;
    win  = (a >= addrLow) && (a <= addrHigh);
    aOn  = c[4] | c[3] | c[2];
    aM   = (c[2] && a == addrLow) || (c[3] && win) || (c[4] && !win);
    diff = (d ^ dataRef) & ~dataIgnore;
    inv  = c[5];
    dOn  = |c[12:6];
    dM   = 1'b0;
    if (sz == 2'd2 && c[12]) dM = (diff == 0) ^ inv;
    if (sz == 2'd1) begin
      if (a[1]) dM = c[11] && ((diff[15:0] == 0) ^ inv);
      else      dM = c[10] && ((diff[31:16] == 0) ^ inv);
    end
    if (sz == 2'd0) begin
      case (a[1:0])
        2'd0: dM = c[6] && ((diff[31:24] == 0) ^ inv);
        2'd1: dM = c[7] && ((diff[23:16] == 0) ^ inv);
        2'd2: dM = c[8] && ((diff[15:8] == 0) ^ inv);
        default: dM = c[9] && ((diff[7:0] == 0) ^ inv);
      endcase
    end
    pOn = c[1];
    pM  = ((((p ^ pcRef) & ~pcIgnore) == 0) ^ c[0]);
    if (!c[13]) return 4'b0000;
    return {aOn && aM, dOn && dM, pOn && pM,
            (aOn || dOn || pOn) && (!aOn || aM) && (!dOn || dM) && (!pOn || pM)};
  endfunction

  // Driver: one strobed cycle, expected result queued for the monitor.
  task automatic drive(input logic [15:0] c, input logic [AW-1:0] a, input logic [31:0] d,
                       input logic [1:0] sz, input logic [PW-1:0] p, input string tag);
    item_t it;
    @(negedge clk);
    ctrlWord = c; busAddr = a; busData = d; busSize = sz; busPc = p;
    busStrobe = 1'b1;
    it.flags = model(c, a, d, sz, p);
    it.tag = tag;
    sbq.push_back(it);
    @(negedge clk);
    busStrobe = 1'b0;
  endtask

  // Monitor: compares outputs 5 ns after each rising edge.
  initial begin
    forever begin
      @(posedge clk);
      #5;
      if (rstN) begin
        if (resultValid !== (sbq.size() > 0)) begin
          checks++; fails++;
          $display("FAIL R1 resultValid actual=%b expected=%b", resultValid, sbq.size() > 0);
        end else if (sbq.size() > 0) begin
          item_t it;
          logic [3:0] got;
          it = sbq.pop_front();
          got = {addrHit, dataHit, pcHit, condMet};
          checks++;
          if (got !== it.flags) begin
            fails++;
            $display("FAIL %s flags actual=%b expected=%b", it.tag, got, it.flags);
          end
        end
      end
    end
  end

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired actual=running expected=done");
    finish_run();
  end

  initial begin
    addrLow = 32'h1000; addrHigh = 32'h10FF;
    dataRef = 32'hA1B2_C3D4; dataIgnore = 32'h0;
    pcRef = 32'h0000_4000; pcIgnore = 32'h0000_00FF;
    repeat (3) @(posedge clk);
    #5;
    checks++; // R1 reset state
    if ({addrHit, dataHit, pcHit, condMet, resultValid} !== 5'b0) begin
      fails++;
      $display("FAIL R1 reset actual=%b expected=00000",
               {addrHit, dataHit, pcHit, condMet, resultValid});
    end
    @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R2 global enable
    drive(AEQ | PCEN, 32'h1000, 0, 2'd2, 32'h4000, "R2");
    // R3 single address
    drive(EN | AEQ, 32'h1000, 0, 2'd2, 0, "R3");
    drive(EN | AEQ, 32'h1004, 0, 2'd2, 0, "R3");
    // R4 inclusive window edges
    drive(EN | ARNG, 32'h1000, 0, 2'd2, 0, "R4");
    drive(EN | ARNG, 32'h10FF, 0, 2'd2, 0, "R4");
    drive(EN | ARNG, 32'h0FFF, 0, 2'd2, 0, "R4");
    drive(EN | ARNG, 32'h1100, 0, 2'd2, 0, "R4");
    // R5 outside window, combined modes
    drive(EN | AOUT, 32'h10FF, 0, 2'd2, 0, "R5");
    drive(EN | AOUT, 32'h1100, 0, 2'd2, 0, "R5");
    drive(EN | AOUT | AEQ, 32'h1000, 0, 2'd2, 0, "R5");
    // R6 lanes and coverage
    drive(EN | BY3, 32'h2000, 32'hA100_0000, 2'd0, 0, "R6");
    drive(EN | BY3, 32'h2001, 32'hA1A1_A1A1, 2'd0, 0, "R6");
    drive(EN | BY0, 32'h2003, 32'h0000_00D4, 2'd0, 0, "R6");
    drive(EN | UWORD, 32'h2000, 32'hA1B2_0000, 2'd1, 0, "R6");
    drive(EN | LWORD, 32'h2002, 32'h0000_C3D4, 2'd1, 0, "R6");
    drive(EN | LWORD, 32'h2000, 32'h0000_C3D4, 2'd1, 0, "R6");
    drive(EN | LONG, 32'h2000, 32'hA1B2_C3D4, 2'd2, 0, "R6");
    drive(EN | LONG, 32'h2000, 32'hA1B2_C3D4, 2'd0, 0, "R6");
    drive(EN | LONG, 32'h2000, 32'hA1B2_C3D4, 2'd3, 0, "R6");
    // R7 data ignore mask
    @(negedge clk); dataIgnore = 32'h0000_00FF;
    drive(EN | LONG, 32'h2000, 32'hA1B2_C300, 2'd2, 0, "R7");
    drive(EN | LONG, 32'h2000, 32'hA0B2_C3D4, 2'd2, 0, "R7");
    @(negedge clk); dataIgnore = 32'h0;
    // R8 data invert
    drive(EN | LONG | DINV, 32'h2000, 32'hA1B2_C3D4, 2'd2, 0, "R8");
    drive(EN | LONG | DINV, 32'h2000, 32'h0, 2'd2, 0, "R8");
    drive(EN | LONG | DINV, 32'h2000, 32'h0, 2'd0, 0, "R8");
    // R9 PC match under mask
    drive(EN | PCEN, 0, 0, 2'd2, 32'h40AB, "R9");
    drive(EN | PCEN, 0, 0, 2'd2, 32'h4100, "R9");
    // R10 PC invert
    drive(EN | PCEN | PCINV, 0, 0, 2'd2, 32'h4100, "R10");
    drive(EN | PCEN | PCINV, 0, 0, 2'd2, 32'h4000, "R10");
    // R11 AND of enabled classes
    drive(EN | ARNG | LONG | DINV, 32'h10FF, 32'h0, 2'd2, 0, "R11");
    drive(EN | ARNG | LONG | DINV, 32'h1100, 32'h0, 2'd2, 0, "R11");
    drive(EN, 32'h1000, 0, 2'd2, 0, "R11");
    drive(EN | AEQ | PCEN, 32'h1000, 0, 2'd2, 32'h5000, "R11");
    drive(EN | AEQ | PCEN, 32'h1000, 0, 2'd2, 32'h4001, "R11");

    // R1 idle cycle after the last strobe
    repeat (2) @(negedge clk);
    checks++;
    if ({addrHit, dataHit, pcHit, condMet, resultValid} !== 5'b0) begin
      fails++;
      $display("FAIL R1 idle actual=%b expected=00000",
               {addrHit, dataHit, pcHit, condMet, resultValid});
    end
    finish_run();
  end

endmodule